// File: doc/BRIEF.md
# Operating Mode Switch Sequencer

This controller holds the operating mode of an audio processing core and only lets that mode change through one fixed sequence. Software first writes the soft-reset register. It then optionally writes the mode-select register. Finally it writes the run register. The new mode becomes active only when the run write is accepted. A write that arrives out of that order is dropped and raises a sticky sequence-error flag. The flag stays set until software reads the status register.

The core supports four modes: compressed-audio decode, ADPCM encode, ADPCM decode and a bypass that passes uncompressed audio through. Each soft reset produces a core reset pulse of fixed length and stops the core. The block also drives an input-source select. That select forces the ADC path while bypass is active. Every other mode takes the serial compressed stream, with the same flow handling as the decode mode.

Top module: `mode_switch_seq`

## Requirements
- R1: Right after a synchronous reset, the outputs are: mode `00` (compressed decode), `core_en` 0, `core_rst` 0, `seq_err` 0 and `src_adc` 0. The controller then waits for a soft-reset write.
- R2: A write to address 0 (soft reset) raises `core_rst` for exactly RST_CYC cycles (default 4), beginning at the clock edge that takes the write. At that same edge it clears `core_en`. The mode does not change.
- R3: The sequence soft reset, then a write to address 1 (mode select, data bits [1:0]), then a write to address 2 (run) makes the selected mode active and sets `core_en` at the edge that takes the run write.
- R4: A mode-select write is discarded and sets `seq_err` in two cases: when no soft reset has come since the last accepted run, and when no soft reset has come since power-up.
- R5: A run write after a soft reset with no mode-select write keeps the previous mode and sets `core_en`.
- R6: A run write is rejected in three cases: when no soft reset has preceded it, when the core is already running, or while `core_rst` is still high. A rejected run write sets `seq_err` and leaves `core_en` and the mode unchanged.
- R7: `core_en` stays low from a soft-reset write until a run write is accepted, whatever other writes arrive in between.
- R8: `src_adc` is 1 exactly when the active mode is `11` (bypass), and 0 in the other three modes.
- R9: A read of address 3 returns {`seq_err`, `core_en`, mode[1:0]} in `rd_data[3:0]` one cycle later and clears `seq_err`. If a new error arrives in the same cycle as the read, the flag stays set.
- R10: The active mode changes only at an accepted run write.
- R11: A second mode-select write before the run replaces the first one.
- R12: A write to address 3 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, valid the cycle after `rd_en` |
| act_mode | output | 2 | Active mode code |
| core_en | output | 1 | Core enable |
| core_rst | output | 1 | Core reset pulse |
| src_adc | output | 1 | 1 selects the ADC input path |
| seq_err | output | 1 | Sticky sequence-error flag |

## Verification
The main stimulus is a vector table of write orderings.
- The legal three-step sequence, which tells a correct mode switch apart from a stuck mode.
- Mode-select and run writes sent without a soft reset, or while the core is running, which show that out-of-order writes are rejected.
- A run write sent straight after a soft reset, which tells "keep the previous mode" apart from "take a stale pending mode".
- Two mode-select writes in a row, which show that the later one wins.

Directed tests then cover the following:
- the exact length of the reset pulse
- a run write sent while the pulse is still high
- the contents of a status read
- an error that arrives in the same cycle as the read that clears the flag

// File: rtl/msw_pkg.sv
package msw_pkg;
  typedef enum logic [1:0] {
    MODE_MPDEC = 2'b00,
    MODE_AENC  = 2'b01,
    MODE_ADEC  = 2'b10,
    MODE_BYP   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ARM  = 2'b01,
    ST_SEL  = 2'b10,
    ST_RUN  = 2'b11
  } seq_st_e;

  localparam int unsigned A_SRST = 0;
  localparam int unsigned A_MODE = 1;
  localparam int unsigned A_RUN  = 2;
  localparam int unsigned A_STAT = 3;
  localparam int unsigned STAT_W = 4;
endpackage

// File: rtl/msw_regif.sv
module msw_regif
  import msw_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [STAT_W-1:0] status,
  output logic              wr_srst,
  output logic              wr_mode,
  output logic              wr_run,
  output logic              rd_stat,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned PAD_W = DATA_W - STAT_W;

  always_comb begin
    wr_srst = wr_en && (wr_addr == ADDR_W'(A_SRST));
    wr_mode = wr_en && (wr_addr == ADDR_W'(A_MODE));
    wr_run  = wr_en && (wr_addr == ADDR_W'(A_RUN));
    rd_stat = rd_en && (rd_addr == ADDR_W'(A_STAT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_stat ? {{PAD_W{1'b0}}, status} : '0;
    end
  end

  p_onehot_strobe_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_srst, wr_mode, wr_run}));
endmodule

// File: rtl/msw_rstpulse.sv
module msw_rstpulse #(
  parameter int unsigned RST_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic core_rst
);
  localparam int unsigned CNT_W = $clog2(RST_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CNT_W'(RST_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign core_rst = (cnt_q != '0);

  p_pulse_start_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> core_rst);
  p_pulse_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(RST_CYC));
endmodule

// File: rtl/msw_seq_fsm.sv
module msw_seq_fsm
  import msw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_srst,
  input  logic       wr_mode,
  input  logic [1:0] mode_in,
  input  logic       wr_run,
  input  logic       rd_stat,
  input  logic       pulse_busy,
  output logic [1:0] act_mode,
  output logic       core_en,
  output logic       src_adc,
  output logic       seq_err
);
  seq_st_e st_q, st_d;
  mode_e   act_q, act_d, pend_q, pend_d;
  logic    en_d, err_ev, run_ok, mode_ok;

  always_comb begin
    mode_ok = (st_q == ST_ARM) || (st_q == ST_SEL);
    run_ok  = mode_ok && !pulse_busy;
    st_d    = st_q;
    act_d   = act_q;
    pend_d  = pend_q;
    en_d    = core_en;
    err_ev  = 1'b0;
    if (wr_srst) begin
      st_d = ST_ARM;
      en_d = 1'b0;
    end else if (wr_mode) begin
      if (mode_ok) begin
        st_d   = ST_SEL;
        pend_d = mode_e'(mode_in);
      end else begin
        err_ev = 1'b1;
      end
    end else if (wr_run) begin
      if (run_ok) begin
        st_d = ST_RUN;
        en_d = 1'b1;
        if (st_q == ST_SEL) act_d = pend_q;
      end else begin
        err_ev = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      act_q   <= MODE_MPDEC;
      pend_q  <= MODE_MPDEC;
      core_en <= 1'b0;
      src_adc <= 1'b0;
      seq_err <= 1'b0;
    end else begin
      st_q    <= st_d;
      act_q   <= act_d;
      pend_q  <= pend_d;
      core_en <= en_d;
      src_adc <= (act_d == MODE_BYP);
      if (err_ev)       seq_err <= 1'b1;
      else if (rd_stat) seq_err <= 1'b0;
    end
  end

  assign act_mode = act_q;

  p_srst_stops_r7: assert property (@(posedge clk) disable iff (rst)
    wr_srst |=> !core_en);
  p_en_needs_run_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(core_en) |-> $past(wr_run));
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_run |=> $stable(act_mode));
  p_bad_mode_err_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_mode && (st_q == ST_RUN || st_q == ST_IDLE)) |=> seq_err);
  p_busy_run_rej_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_run && pulse_busy) |=> (seq_err && !core_en));
  p_src_bypass_r8: assert property (@(posedge clk) disable iff (rst)
    src_adc == (act_mode == 2'b11));
endmodule

// File: rtl/mode_switch_seq.sv
module mode_switch_seq
  import msw_pkg::*;
#(
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        act_mode,
  output logic              core_en,
  output logic              core_rst,
  output logic              src_adc,
  output logic              seq_err
);
  logic wr_srst, wr_mode, wr_run, rd_stat;
  logic [STAT_W-1:0] status;

  assign status = {seq_err, core_en, act_mode};

  msw_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_en(rd_en), .rd_addr(rd_addr), .status(status),
    .wr_srst(wr_srst), .wr_mode(wr_mode), .wr_run(wr_run),
    .rd_stat(rd_stat), .rd_data(rd_data)
  );

  msw_rstpulse #(.RST_CYC(RST_CYC)) u_pulse (
    .clk(clk), .rst(rst), .start(wr_srst), .core_rst(core_rst)
  );

  msw_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .wr_srst(wr_srst), .wr_mode(wr_mode),
    .mode_in(wr_data[1:0]), .wr_run(wr_run), .rd_stat(rd_stat),
    .pulse_busy(core_rst), .act_mode(act_mode), .core_en(core_en),
    .src_adc(src_adc), .seq_err(seq_err)
  );

  p_err_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !wr_en) |=> !seq_err);
endmodule

// File: tb/tb_mode_switch_seq.sv
module tb_mode_switch_seq;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NVEC   = 19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic [1:0] act_mode;
  logic core_en, core_rst, src_adc, seq_err;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  mode_switch_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_CYC(4)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .act_mode(act_mode),
    .core_en(core_en), .core_rst(core_rst), .src_adc(src_adc), .seq_err(seq_err)
  );

  // vector: {is_read, addr[1:0], data[7:0], exp_mode[1:0], exp_en, exp_err}
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b0, 2'd1, 8'h01, 2'd0, 1'b0, 1'b1},  // R4 mode w/o soft reset
    {1'b1, 2'd3, 8'h00, 2'd0, 1'b0, 1'b0},  // R9 read clears
    {1'b0, 2'd2, 8'h00, 2'd0, 1'b0, 1'b1},  // R6 run w/o soft reset
    {1'b1, 2'd3, 8'h00, 2'd0, 1'b0, 1'b0},  // R9
    {1'b0, 2'd0, 8'h00, 2'd0, 1'b0, 1'b0},  // R2 soft reset
    {1'b0, 2'd1, 8'h02, 2'd0, 1'b0, 1'b0},  // R7 pending, still off
    {1'b0, 2'd2, 8'h00, 2'd2, 1'b1, 1'b0},  // R3 run -> ADPCM dec
    {1'b0, 2'd1, 8'h03, 2'd2, 1'b1, 1'b1},  // R4 mode while running
    {1'b1, 2'd3, 8'h00, 2'd2, 1'b1, 1'b0},  // R9
    {1'b0, 2'd0, 8'h00, 2'd2, 1'b0, 1'b0},  // R2
    {1'b0, 2'd2, 8'h00, 2'd2, 1'b1, 1'b0},  // R5 run keeps mode
    {1'b0, 2'd2, 8'h00, 2'd2, 1'b1, 1'b1},  // R6 run while running
    {1'b1, 2'd3, 8'h00, 2'd2, 1'b1, 1'b0},  // R9
    {1'b0, 2'd0, 8'h00, 2'd2, 1'b0, 1'b0},  // R2
    {1'b0, 2'd1, 8'h01, 2'd2, 1'b0, 1'b0},  // R11 first choice
    {1'b0, 2'd1, 8'h03, 2'd2, 1'b0, 1'b0},  // R11 override
    {1'b0, 2'd2, 8'h00, 2'd3, 1'b1, 1'b0},  // R11/R8 bypass active
    {1'b0, 2'd3, 8'hFF, 2'd3, 1'b1, 1'b0},  // R12 write to status addr
    {1'b0, 2'd0, 8'h00, 2'd3, 1'b0, 1'b0}   // R10 mode kept on soft reset
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_rd;
    @(negedge clk); rd_en = 1'b1; rd_addr = 2'd3;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int pulse_len;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mode", act_mode, 0);
    chk("R1 en", core_en, 0);
    chk("R1 rst", core_rst, 0);
    chk("R1 err", seq_err, 0);
    chk("R1 src", src_adc, 0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][14]) do_rd();
      else do_wr(VEC[i][13:12], VEC[i][11:4]);
      chk($sformatf("vec%0d mode R3/R10", i), act_mode, VEC[i][3:2]);
      chk($sformatf("vec%0d en R7", i), core_en, VEC[i][1]);
      chk($sformatf("vec%0d err R4/R6", i), seq_err, VEC[i][0]);
      chk($sformatf("vec%0d src R8", i), src_adc, VEC[i][3:2] == 2'd3);
      idle(5);
    end

    // R2: exact pulse length
    do_wr(2'd0, 8'h00);
    pulse_len = 0;
    while (core_rst && pulse_len < 20) begin
      pulse_len++;
      @(negedge clk);
    end
    chk("R2 pulse length", pulse_len, 4);
    chk("R2 en cleared", core_en, 0);

    // R6: run during pulse rejected
    do_wr(2'd0, 8'h00);
    do_wr(2'd2, 8'h00);
    chk("R6 run in pulse en", core_en, 0);
    chk("R6 run in pulse err", seq_err, 1);
    do_rd();
    chk("R9 rd_data", rd_data[3:0], 4'b1011);
    chk("R9 cleared", seq_err, 0);
    idle(5);
    do_wr(2'd1, 8'h01);
    do_wr(2'd2, 8'h00);
    chk("R3 mode encode", act_mode, 1);
    chk("R8 src not adc", src_adc, 0);
    chk("R3 en", core_en, 1);

    // R9: error set in the same cycle as a status read wins
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h00;
    rd_en = 1'b1; rd_addr = 2'd3;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R9 set wins", seq_err, 1);
    chk("R9 rd_data prior", rd_data[3:0], 4'b0101);
    chk("R4 mode unchanged", act_mode, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule